// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block is the transmit half of a serial port running in synchronous slave mode. An external master owns the shift clock. The block watches that clock and moves one data bit onto its output line for each falling edge. Software loads characters through a one-entry holding register that feeds a shift register, so a second character can wait while the first one is still shifting out.

A transfer runs only while the control inputs select synchronous slave transmit: synchronous mode on, master select off, port enabled, both receive enables off and transmit enabled. A ninth data bit can be sent after the low byte. That bit is written to its own staging register before the low byte, because the low-byte write is what starts the transfer. A buffer-empty flag and a shift-register-empty status report progress. An interrupt request is raised from the buffer-empty flag when the transmit and peripheral interrupt enables are both set, and a vectored request is raised when the global enable is also set.

Top module: `sync_slave_tx`

## Requirements
- R1: Shifting and loading take place only while sync_mode=1, master_sel=0, port_en=1, rx_single_en=0, rx_cont_en=0 and tx_en=1. In any other setting with port_en=1 and tx_en=1, the shift state is frozen and held, writes still go into the holding register, and sdo rests at 1.
- R2: A data_wr while transfers are allowed, the shifter is idle and the holding register is empty loads the shifter at that clock edge. After that edge sdo shows data_in[0], shift_empty=0 and buf_empty stays 1.
- R3: Bits leave least significant first. The ext_sclk level is sampled into two synchronizer flops. sdo moves to the next bit after the second system-clock rising edge following the first edge that samples ext_sclk low after a high.
- R4: When nine_mode=1 at the moment a character is loaded, the character is nine bits long and its last bit is the staged ninth bit. stage_wr writes stage_bit into the staging register. A data_wr in the same cycle as stage_wr captures the previous staged value.
- R5: A data_wr while the shifter is busy and the holding register is empty stores the word and clears buf_empty. buf_empty returns to 1 after the edge that consumes the falling clock edge ending the current character, and the held word starts at that same edge.
- R6: A data_wr while the holding register is full is dropped, and the held word is sent unchanged.
- R7: shift_empty is 1 exactly when no character is in the shifter. It clears when a character is loaded and sets after the final bit is consumed if the holding register is empty. A data_wr that arrives in the cycle the final bit is consumed goes to the holding register and is loaded one edge later.
- R8: irq_req = buf_empty AND tx_ie AND periph_ie; irq_out = irq_req AND global_ie.
- R9: While port_en=0 or tx_en=0, both registers are emptied at each clock edge, so buf_empty=1, shift_empty=1 and sdo=1. A transfer that was in progress is lost.
- R10: After reset, buf_empty=1, shift_empty=1, sdo=1 and the staged ninth bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | Synchronous mode select |
| master_sel | input | 1 | 1 = clock master, 0 = slave |
| port_en | input | 1 | Serial port enable |
| rx_single_en | input | 1 | Single-character receive enable |
| rx_cont_en | input | 1 | Continuous receive enable |
| tx_en | input | 1 | Transmit enable |
| nine_mode | input | 1 | Nine-bit character select |
| stage_wr | input | 1 | Write strobe for the staged ninth bit |
| stage_bit | input | 1 | Ninth-bit value to stage |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | 8 | Low data byte |
| tx_ie | input | 1 | Transmit interrupt enable |
| periph_ie | input | 1 | Peripheral interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| ext_sclk | input | 1 | Shift clock from the external master |
| sdo | output | 1 | Serial data line, rests high |
| buf_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shift register empty |
| irq_req | output | 1 | Enabled buffer-empty request |
| irq_out | output | 1 | Request qualified by the global enable |

## Verification
The risky overlap is a new data_wr landing in the same cycle that the last bit of a character is consumed. In that cycle the holding path and the direct-load path both look eligible. The bench provokes this by holding the final low phase of ext_sclk and sweeping the write over every cycle offset around the synchronized edge, so a few offsets hit the consuming edge exactly. A behavioural model built from bit queues predicts, for each offset, whether the word waits one cycle in the holding register. It then compares buf_empty, shift_empty and every bit on sdo cycle by cycle.

// File: rtl/sst_pkg.sv
package sst_pkg;
    localparam int DATA_W   = 8;
    localparam int CHAR_MAX = DATA_W + 1;
    localparam int CNT_W    = $clog2(CHAR_MAX + 1);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic              ninth;
        logic [DATA_W-1:0] low;
    } tx_word_t;

    typedef struct packed {
        logic sync_mode;
        logic master_sel;
        logic port_en;
        logic rx_single;
        logic rx_cont;
        logic tx_en;
    } tx_cfg_t;

    function automatic logic slave_tx_sel(tx_cfg_t c);
        return c.sync_mode & ~c.master_sel & c.port_en &
               ~c.rx_single & ~c.rx_cont & c.tx_en;
    endfunction

    function automatic logic tx_alive(tx_cfg_t c);
        return c.port_en & c.tx_en;
    endfunction
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    output logic fall_pulse
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){IDLE}};
        else     chain <= {chain[STAGES-1:0], sclk_in};
    end

    assign fall_pulse = chain[STAGES] & ~chain[STAGES-1];

    a_r3_fall_isolated: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse);
endmodule

// File: rtl/sst_holding.sv
module sst_holding
    import sst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     put,
    input  logic     take,
    input  tx_word_t put_word,
    output logic     full,
    output tx_word_t word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full <= 1'b0;
            if (rst) word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (put) begin
            full <= 1'b1;
            word <= put_word;
        end
    end

    a_r6_full_keeps_word: assert property (@(posedge clk) disable iff (rst)
        full && !take && !clear |=> full && $stable(word));
    a_r5_take_empties: assert property (@(posedge clk) disable iff (rst)
        take |=> !full);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
    import sst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     run,
    input  logic     fall,
    input  logic     load,
    input  tx_word_t load_word,
    input  logic     load_nine,
    output logic     busy,
    output logic     done,
    output logic     line_bit
);
    logic [DATA_W:0]  sreg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             step;

    assign step = run & busy & fall;
    assign done = step & (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy <= 1'b0;
            sreg <= '0;
            cnt  <= '0;
            last <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sreg <= {load_word.ninth, load_word.low};
            cnt  <= '0;
            last <= load_nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (step) begin
            sreg <= {1'b0, sreg[DATA_W:1]};
            cnt  <= cnt + CNT_W'(1);
        end
    end

    assign line_bit = sreg[0];

    a_r1_hold_when_gated: assert property (@(posedge clk) disable iff (rst)
        busy && !run && !clear && !load |=> $stable(sreg) && $stable(cnt));
    a_r7_load_sets_busy: assert property (@(posedge clk) disable iff (rst)
        load && !clear |=> busy);
    a_r3_one_bit_per_edge: assert property (@(posedge clk) disable iff (rst)
        step && !done && !clear && !load |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
    import sst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic              master_sel,
    input  logic              port_en,
    input  logic              rx_single_en,
    input  logic              rx_cont_en,
    input  logic              tx_en,
    input  logic              nine_mode,
    input  logic              stage_wr,
    input  logic              stage_bit,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              tx_ie,
    input  logic              periph_ie,
    input  logic              global_ie,
    input  logic              ext_sclk,
    output logic              sdo,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq_req,
    output logic              irq_out
);
    tx_cfg_t  cfg;
    tx_word_t hold_word, load_word;
    logic act, alive, staged, fall;
    logic hold_full, busy, done, line_bit;
    logic accept, direct, to_hold, take, load;

    assign cfg = '{sync_mode: sync_mode, master_sel: master_sel, port_en: port_en,
                   rx_single: rx_single_en, rx_cont: rx_cont_en, tx_en: tx_en};
    assign act   = slave_tx_sel(cfg);
    assign alive = tx_alive(cfg);

    always_ff @(posedge clk) begin
        if (rst)           staged <= 1'b0;
        else if (stage_wr) staged <= stage_bit;
    end

    sst_clk_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst(rst), .sclk_in(ext_sclk), .fall_pulse(fall));

    assign accept  = data_wr & ~hold_full;
    assign direct  = accept & act & ~busy;
    assign to_hold = accept & ~direct;
    assign take    = act & hold_full & (~busy | done);
    assign load    = take | direct;
    assign load_word = direct ? tx_word_t'{ninth: staged, low: data_in} : hold_word;

    sst_holding u_hold (
        .clk(clk), .rst(rst), .clear(~alive), .put(to_hold), .take(take),
        .put_word(tx_word_t'{ninth: staged, low: data_in}),
        .full(hold_full), .word(hold_word));

    sst_shifter u_shift (
        .clk(clk), .rst(rst), .clear(~alive), .run(act), .fall(fall),
        .load(load), .load_word(load_word), .load_nine(nine_mode),
        .busy(busy), .done(done), .line_bit(line_bit));

    assign sdo         = (act & busy) ? line_bit : 1'b1;
    assign buf_empty   = ~hold_full;
    assign shift_empty = ~busy;
    assign irq_req     = buf_empty & tx_ie & periph_ie;
    assign irq_out     = irq_req & global_ie;

    a_r9_abort_flushes: assert property (@(posedge clk) disable iff (rst)
        !alive |=> buf_empty && shift_empty);
    a_r2_direct_keeps_empty: assert property (@(posedge clk) disable iff (rst)
        direct |=> buf_empty && !shift_empty);
    a_r5_flag_after_handoff: assert property (@(posedge clk) disable iff (rst)
        busy && done && hold_full && alive |=> buf_empty && !shift_empty);
endmodule

// File: tb/test_sync_slave_tx.sv
`timescale 1ns/1ps
module test_sync_slave_tx;
    logic clk = 1'b0, rst = 1'b1;
    logic sync_mode = 0, master_sel = 0, port_en = 0, rx_single_en = 0, rx_cont_en = 0, tx_en = 0;
    logic nine_mode = 0, stage_wr = 0, stage_bit = 0, data_wr = 0;
    logic [7:0] data_in = '0;
    logic tx_ie = 0, periph_ie = 0, global_ie = 0, ext_sclk = 1'b1;
    logic sdo, buf_empty, shift_empty, irq_req, irq_out;
    int n_chk = 0, n_err = 0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    sync_slave_tx i_sync_slave_tx (.*);

    // behavioural reference: bit queues, no counters
    bit m_sq[$] = '{1, 1, 1};
    bit m_bits[$];
    bit m_busy, m_hold_full, m_stage;
    bit [8:0] m_hold;

    function automatic bit cfg_act();
        return port_en && tx_en && sync_mode && !master_sel && !rx_single_en && !rx_cont_en;
    endfunction

    task automatic m_load(bit [8:0] w);
        m_bits.delete();
        for (int i = 0; i < 8; i++) m_bits.push_back(w[i]);
        if (nine_mode) m_bits.push_back(w[8]);
        m_busy = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sq = '{1, 1, 1}; m_bits.delete(); m_busy = 0; m_hold_full = 0; m_stage = 0; m_hold = '0;
        end else begin
            bit fall, act, ob, ohf, fin, acc, dir, toh, tk, old_stage;
            fall = m_sq[2] && !m_sq[1];
            m_sq.push_front(ext_sclk); void'(m_sq.pop_back());
            act = cfg_act();
            old_stage = m_stage;
            if (stage_wr) m_stage = stage_bit;
            if (!(port_en && tx_en)) begin
                m_bits.delete(); m_busy = 0; m_hold_full = 0;
            end else begin
                ob = m_busy; ohf = m_hold_full;
                fin = act && ob && fall && m_bits.size() == 1;
                if (act && ob && fall) begin
                    void'(m_bits.pop_front());
                    if (fin) m_busy = 0;
                end
                acc = data_wr && !ohf;
                dir = acc && act && !ob;
                toh = acc && !dir;
                tk  = act && ohf && (!ob || fin);
                if (dir) m_load({old_stage, data_in});
                if (tk) begin m_load(m_hold); m_hold_full = 0; end
                if (toh) begin m_hold_full = 1; m_hold = {old_stage, data_in}; end
            end
        end
    end

    task automatic chk(string req, string what, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            bit e_sdo, e_be;
            e_sdo = (cfg_act() && m_busy) ? m_bits[0] : 1'b1;
            e_be  = !m_hold_full;
            chk(cur_req, "sdo (R3)", sdo, e_sdo);
            chk(cur_req, "buf_empty (R5)", buf_empty, e_be);
            chk(cur_req, "shift_empty (R7)", shift_empty, !m_busy);
            chk(cur_req, "irq_req (R8)", irq_req, e_be && tx_ie && periph_ie);
            chk(cur_req, "irq_out (R8)", irq_out, e_be && tx_ie && periph_ie && global_ie);
        end
    end

    task automatic step(); @(posedge clk); #2; endtask
    task automatic pulse();
        ext_sclk = 0; repeat (4) step();
        ext_sclk = 1; repeat (4) step();
    endtask
    task automatic wr(logic [7:0] b);
        data_in = b; data_wr = 1; step(); data_wr = 0;
    endtask
    task automatic go_slave_tx();
        sync_mode = 1; master_sel = 0; port_en = 1; rx_single_en = 0; rx_cont_en = 0; tx_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 0; step();
        cur_req = "R10";
        chk("R10", "reset buf_empty", buf_empty, 1);
        chk("R10", "reset shift_empty", shift_empty, 1);
        chk("R10", "reset sdo", sdo, 1);

        // R1: mode gating
        cur_req = "R1";
        port_en = 1; tx_en = 1;
        wr(8'h55); pulse(); pulse();
        sync_mode = 1; step(); pulse(); pulse();
        rx_single_en = 1; pulse(); pulse(); rx_single_en = 0; pulse();
        rx_cont_en = 1; pulse(); rx_cont_en = 0; pulse();
        master_sel = 1; pulse(); master_sel = 0;
        repeat (6) pulse();
        // R9: abort through tx_en
        cur_req = "R9";
        tx_en = 0; step(); tx_en = 1; step();

        // R2/R3: direct load, LSB first
        cur_req = "R2";
        go_slave_tx(); wr(8'hA5);
        cur_req = "R3";
        repeat (9) pulse();

        // R5/R6: double buffer, dropped third write
        cur_req = "R5";
        wr(8'h3C); wr(8'hC3);
        cur_req = "R6";
        wr(8'hFF);
        cur_req = "R5";
        repeat (18) pulse();

        // R4: ninth bit staging
        cur_req = "R4";
        nine_mode = 1;
        stage_bit = 1; stage_wr = 1; step(); stage_wr = 0;
        wr(8'h81);
        stage_bit = 0; stage_wr = 1; data_in = 8'h7E; data_wr = 1; step();
        stage_wr = 0; data_wr = 0;
        repeat (20) pulse();
        nine_mode = 0;

        // R8: interrupt gating
        cur_req = "R8";
        tx_ie = 1; step(); periph_ie = 1; step(); global_ie = 1; step();
        wr(8'h12); wr(8'h34); pulse(); periph_ie = 0; pulse(); periph_ie = 1;
        repeat (16) pulse();
        global_ie = 0; step(); tx_ie = 0; step();

        // R9: abort through port_en mid-character with full holding register
        cur_req = "R9";
        wr(8'h0F); pulse(); pulse(); wr(8'hF0);
        port_en = 0; step(); step(); port_en = 1;
        pulse(); pulse();
        wr(8'hE7); pulse(); tx_en = 0; step(); tx_en = 1; pulse();

        // R7: write swept around the cycle that consumes the final bit
        cur_req = "R7";
        for (int d = 0; d < 8; d++) begin
            wr(8'h96);
            repeat (7) pulse();
            ext_sclk = 0;
            repeat (d) step();
            wr(8'h69);
            repeat (4) step();
            ext_sclk = 1; repeat (4) step();
            repeat (10) pulse();
        end

        step();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule